// File: doc/BRIEF.md
# Post-Transmit Interframe Deferral Timer

This block decides when a half-duplex 10 Mb/s CSMA/CD MAC may start its next frame after its own transmission has ended. It advances only on cycles where a one-bit-time clock enable is high. When the transmit-active flag drops, the block first runs a blinding window. During that window receive carrier is ignored, so the transceiver's heartbeat test burst cannot be mistaken for traffic. The burst is a short 10 MHz signal of 5 to 15 bit times that starts about 0.6 to 1.6 µs after the frame ends.

With two-part deferral enabled, the blinding window is followed by two phases. In the first phase, carrier restarts the phase's own timing but never the blinding window. In the second phase, carrier is ignored until the 96-bit gap is complete. With the feature disabled, one carrier-blind gap of 96 bit times follows the blinding window. The ready output is a registered level. It stays high until the next transmission begins, and a new transmission aborts any deferral that is still running.

Top module: `post_tx_defer`

## Requirements
- R1: During and after reset, with no transmission since, `defer_done_o` is 1.
- R2: One cycle after any cycle in which `tx_active_i` is 1, `defer_done_o` is 0. A transmission started in the middle of a deferral aborts it, and the next gap is timed from the start.
- R3: For the first 40 bit-enables after `tx_active_i` falls (the blinding window), `crs_i` has no effect on the ready time.
- R4: With `two_part_dis_i` = 0 and no carrier after the blinding window, `defer_done_o` rises on the clock edge of the 96th bit-enable after transmit ends. This is 40 blinding, then 20 first-phase, then 36 second-phase enables.
- R5: Carrier seen after the blinding window and before the first phase completes restarts only the first phase. If carrier is seen when c enables have been counted (40 ≤ c < 60), ready rises at enable c+56.
- R6: Carrier seen once 60 enables have been counted in two-part mode has no effect on the ready time.
- R7: With `two_part_dis_i` = 1 (feature disabled), ready rises at enable 40+96 = 136 and carrier is ignored throughout.
- R8: Only cycles with `bit_en_i` = 1 advance the timing. Once high, `defer_done_o` stays high whatever `crs_i` does, until `tx_active_i` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle pulse per bit time |
| tx_active_i | input | 1 | High while this node transmits |
| crs_i | input | 1 | Receive carrier sense |
| two_part_dis_i | input | 1 | 1 disables two-part deferral; sampled when the blinding window ends |
| defer_done_o | output | 1 | Deferral complete; next transmission permitted |

## Verification
The assertions assume that `bit_en_i` is a single-cycle pulse and that `two_part_dis_i` is stable across a gap. They also assume that the counter only moves when an enable is present or when carrier or transmit forces a clear. The stimulus places each bit-enable on its own cycle, followed by at least one idle cycle. Single-cycle carrier pulses go into those idle cycles, so every restart lands at a known count. Long carrier stretches are applied only inside the blinding window. The mode input changes only between gaps.

// File: rtl/post_tx_defer_pkg.sv
package post_tx_defer_pkg;
  typedef enum logic [2:0] {
    ST_TX    = 3'd0,
    ST_BLIND = 3'd1,
    ST_PH1   = 3'd2,
    ST_PH2   = 3'd3,
    ST_GAP   = 3'd4,
    ST_DONE  = 3'd5
  } defer_state_e;
endpackage

// File: rtl/defer_cnt.sv
module defer_cnt #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0)); // R2
endmodule

// File: rtl/defer_fsm.sv
module defer_fsm
  import post_tx_defer_pkg::*;
#(
  parameter int BLIND_BITS = 40,
  parameter int PH1_BITS   = 20,
  parameter int PH2_BITS   = 36,
  parameter int GAP_BITS   = 96,
  parameter int W          = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_en_i,
  input  logic         tx_active_i,
  input  logic         crs_i,
  input  logic         two_part_dis_i,
  input  logic [W-1:0] cnt_i,
  output logic         cnt_clr_o,
  output logic         cnt_inc_o,
  output logic         done_o
);
  localparam logic [W-1:0] BLIND_LAST = W'(BLIND_BITS - 1);
  localparam logic [W-1:0] PH1_LAST   = W'(PH1_BITS - 1);
  localparam logic [W-1:0] PH2_LAST   = W'(PH2_BITS - 1);
  localparam logic [W-1:0] GAP_LAST   = W'(GAP_BITS - 1);

  defer_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    if (tx_active_i) begin
      state_d   = ST_TX;
      cnt_clr_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_TX: begin
          state_d   = ST_BLIND;
          cnt_clr_o = 1'b1;
        end
        ST_BLIND: if (bit_en_i) begin
          if (cnt_i == BLIND_LAST) begin
            cnt_clr_o = 1'b1;
            state_d   = two_part_dis_i ? ST_GAP : ST_PH1;
          end else cnt_inc_o = 1'b1;
        end
        ST_PH1: begin
          if (crs_i) cnt_clr_o = 1'b1;  // restart phase one only
          else if (bit_en_i) begin
            if (cnt_i == PH1_LAST) begin
              cnt_clr_o = 1'b1;
              state_d   = ST_PH2;
            end else cnt_inc_o = 1'b1;
          end
        end
        ST_PH2: if (bit_en_i) begin
          if (cnt_i == PH2_LAST) begin
            cnt_clr_o = 1'b1;
            state_d   = ST_DONE;
          end else cnt_inc_o = 1'b1;
        end
        ST_GAP: if (bit_en_i) begin
          if (cnt_i == GAP_LAST) begin
            cnt_clr_o = 1'b1;
            state_d   = ST_DONE;
          end else cnt_inc_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DONE;
      done_o  <= 1'b1;
    end else begin
      state_q <= state_d;
      done_o  <= (state_d == ST_DONE);
    end
  end

  AST_TX_DROPS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_active_i |=> !done_o); // R2
  AST_BLIND_IGNORES_CRS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BLIND && !tx_active_i && bit_en_i && cnt_i != BLIND_LAST)
      |=> (cnt_i == $past(cnt_i) + 1'b1)); // R3
  AST_PH1_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PH1 && !tx_active_i && crs_i) |=> (cnt_i == '0 && state_q == ST_PH1)); // R5
  AST_PH2_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PH2 && !tx_active_i && bit_en_i && cnt_i != PH2_LAST)
      |=> (cnt_i == $past(cnt_i) + 1'b1)); // R6
  AST_GAP_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP && !tx_active_i && bit_en_i && cnt_i != GAP_LAST)
      |=> (cnt_i == $past(cnt_i) + 1'b1)); // R7
  AST_DONE_ON_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(bit_en_i)); // R8
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !tx_active_i) |=> done_o); // R8
  AST_NO_STEP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_en_i && !tx_active_i && state_q != ST_TX && state_q != ST_PH1) |=> $stable(cnt_i)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= GAP_LAST); // R4
endmodule

// File: rtl/post_tx_defer.sv
module post_tx_defer #(
  parameter int BLIND_BITS = 40,
  parameter int PH1_BITS   = 20,
  parameter int PH2_BITS   = 36,
  parameter int GAP_BITS   = 96
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic tx_active_i,
  input  logic crs_i,
  input  logic two_part_dis_i,
  output logic defer_done_o
);
  localparam int MAX_A = (BLIND_BITS > PH1_BITS) ? BLIND_BITS : PH1_BITS;
  localparam int MAX_B = (PH2_BITS > GAP_BITS) ? PH2_BITS : GAP_BITS;
  localparam int MAX_N = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_N + 1);

  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_inc;

  defer_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  defer_fsm #(
    .BLIND_BITS (BLIND_BITS),
    .PH1_BITS   (PH1_BITS),
    .PH2_BITS   (PH2_BITS),
    .GAP_BITS   (GAP_BITS),
    .W          (CNT_W)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .bit_en_i       (bit_en_i),
    .tx_active_i    (tx_active_i),
    .crs_i          (crs_i),
    .two_part_dis_i (two_part_dis_i),
    .cnt_i          (cnt),
    .cnt_clr_o      (cnt_clr),
    .cnt_inc_o      (cnt_inc),
    .done_o         (defer_done_o)
  );
endmodule

// File: tb/post_tx_defer_tb.sv
module post_tx_defer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, tx = 1'b0, crs = 1'b0, dis = 1'b0;
  logic done;
  int   n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  post_tx_defer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .tx_active_i(tx),
    .crs_i(crs), .two_part_dis_i(dis), .defer_done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_tx(input int cycles);
    @(negedge clk); tx = 1'b1;
    repeat (cycles) @(negedge clk);
    check(done == 1'b0, "R2 done low during tx", int'(done), 0);
    tx = 1'b0;
    @(negedge clk);
  endtask

  // enables one at a time; hold carrier for enables in (h_lo,h_hi], pulse after p_at enables
  task automatic run_gap(input bit mode, input int h_lo, input int h_hi, input int p_at,
                         input int idle, input int exp, input string req);
    int first = 0;
    dis = mode;
    for (int n = 1; n <= exp + 4; n++) begin
      @(negedge clk);
      bit_en = 1'b1;
      crs = (n > h_lo && n <= h_hi);
      @(negedge clk);
      bit_en = 1'b0;
      crs = (n == p_at) || (n > h_lo && n < h_hi);
      if (done && first == 0) first = n;
      repeat (idle) @(negedge clk);
      if (first != 0) break;
    end
    crs = 1'b0;
    @(negedge clk);
    check(first == exp, req, first, exp);
  endtask

  task automatic t_reset();
    check(done == 1'b1, "R1 done in reset", int'(done), 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R1 done after reset", int'(done), 1);
  endtask

  task automatic t_plain();
    do_tx(5);
    run_gap(1'b0, 0, 0, 0, 0, 96, "R4 plain two-part gap");
  endtask

  task automatic t_blind();
    do_tx(3);
    run_gap(1'b0, 2, 39, 39, 0, 96, "R3 carrier in blinding window");
  endtask

  task automatic t_ph1();
    do_tx(3);
    run_gap(1'b0, 0, 0, 50, 0, 106, "R5 carrier mid phase one");
    do_tx(3);
    run_gap(1'b0, 0, 0, 59, 0, 115, "R5 carrier at last phase-one bit");
    do_tx(3);
    run_gap(1'b0, 0, 0, 40, 0, 96, "R5 carrier at phase-one start");
  endtask

  task automatic t_ph2();
    do_tx(3);
    run_gap(1'b0, 0, 0, 60, 0, 96, "R6 carrier at phase-two start");
    do_tx(3);
    run_gap(1'b0, 0, 0, 80, 0, 96, "R6 carrier mid phase two");
  endtask

  task automatic t_disabled();
    do_tx(3);
    run_gap(1'b1, 0, 0, 0, 0, 136, "R7 single gap");
    do_tx(3);
    run_gap(1'b1, 5, 30, 50, 0, 136, "R7 carrier ignored in single gap");
    dis = 1'b0;
  endtask

  task automatic t_gating();
    do_tx(3);
    run_gap(1'b0, 0, 0, 0, 3, 96, "R8 idle cycles do not count");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); crs = i[0]; bit_en = i[1];
    end
    @(negedge clk); crs = 1'b0; bit_en = 1'b0;
    check(done == 1'b1, "R8 done holds until tx", int'(done), 1);
  endtask

  task automatic t_abort();
    do_tx(3);
    for (int n = 0; n < 70; n++) begin
      @(negedge clk); bit_en = 1'b1;
      @(negedge clk); bit_en = 1'b0;
    end
    check(done == 1'b0, "R2 not done before abort", int'(done), 0);
    do_tx(4);
    run_gap(1'b0, 0, 0, 0, 0, 96, "R2 abort restarts full gap");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_plain();
    t_blind();
    t_ph1();
    t_ph2();
    t_disabled();
    t_gating();
    t_hold();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule